// File: doc/BRIEF.md
# Machine Trap Capture Controller

This block sits in the control path of a small in-order 32-bit core. It collects synchronous exception strobes and the three machine-level interrupt lines (software, timer, external) into sticky buffers. It picks one trap by fixed priority and latches the trap's cause code together with a snapshot of the buffered exception sources. It then starts the trap handler through a request/acknowledge handshake with the execute engine. Only one trap can be outstanding at a time. Requests that arrive while a trap is pending stay in the buffers and are taken once the engine has acknowledged.

The control state machine has two states. `CTL_IDLE` means no trap is outstanding. `CTL_WAIT` means a trap-start request is being held. The ACCEPT transition goes from `CTL_IDLE` to `CTL_WAIT` when an exception is buffered, or when an eligible interrupt is buffered and the execute engine is in a state that admits interrupts. The START_ACKED transition goes from `CTL_WAIT` to `CTL_IDLE` when the engine returns its start acknowledge. On ACCEPT the block also issues a one-cycle clear for the captured exception sources and a one-cycle acknowledge mask for the chosen interrupt. Each of these strobes removes only the buffered bits it refers to.

Top module: `trap_capture_ctrl`

## Requirements
- R1: While reset is low, and directly after it, the cause, captured source vector, clear strobe, interrupt acknowledge mask, start request and pending view are all zero.
- R2: Exception strobe bit 0 (instruction address misaligned), bit 1 (instruction access fault) and bit 2 (illegal instruction) yield cause codes 0, 1 and 2, MSB clear. The lowest buffered index wins. An exception is accepted in any engine state. The source output holds the buffered exception vector from the accepting cycle. The cause is visible two clock edges after the strobe is sampled.
- R3: Interrupt line bit 0 (software), bit 1 (timer) and bit 2 (external) yield causes 0x80000003, 0x80000007 and 0x8000000B. When several interrupts are eligible, external wins over software, and software wins over timer.
- R4: An interrupt is eligible only while its enable bit and the global enable are both 1.
- R5: Interrupts are accepted only while the engine state input equals 2 (execute) or 3 (trap). A buffered exception always wins over any interrupt.
- R6: The start request rises on acceptance. It stays high until a cycle with the start acknowledge high, and it is low in the following cycle.
- R7: While a start request is outstanding, nothing new is accepted and the cause does not change. Requests arriving meanwhile stay buffered and are taken after the acknowledge.
- R8: Each acceptance drives the exception clear strobe high for exactly one cycle. For an interrupt trap, it also drives an acknowledge mask for exactly one cycle, with only the chosen line's bit set (same bit order as R3). For an exception trap the mask is zero. Each strobe clears only its own buffered bits.
- R9: The pending view shows the buffered software, timer and external requests on bits 3, 7 and 11, regardless of the enables. All other bits are zero. The chosen interrupt's bit reads zero once its acknowledge has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_strobe_i | input | 3 | Exception request strobes, bit = cause code |
| irq_i | input | 3 | Interrupt lines: 0 software, 1 timer, 2 external |
| irq_en_i | input | 3 | Per-line interrupt enable, same order |
| gie_i | input | 1 | Global interrupt enable |
| eng_state_i | input | 3 | Execute-engine state code (2 execute, 3 trap) |
| start_ack_i | input | 1 | Execute engine accepted the trap start |
| mcause_o | output | 32 | Latched trap cause |
| exc_src_o | output | 3 | Latched exception-source snapshot |
| exc_clr_o | output | 1 | One-cycle exception clear strobe |
| irq_ack_o | output | 3 | One-cycle interrupt acknowledge mask |
| start_req_o | output | 1 | Trap-start request to the execute engine |
| mip_o | output | 32 | Pending-interrupt read view |

## Verification
The assertions take for granted two things about the inputs. The execute engine raises its start acknowledge only while a request is outstanding. The engine state is a settled code at each rising edge. The stimulus changes every input on the falling clock edge. It pulses the acknowledge for a single cycle, and only after the request has been observed high. Each table vector starts from a fresh reset, so buffered leftovers from one pattern never leak into the next.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;

    localparam int XLEN    = 32;
    localparam int NUM_EXC = 3;
    localparam int NUM_IRQ = 3;
    localparam int ENG_W   = 3;

    localparam int IRQ_SW  = 0;
    localparam int IRQ_TMR = 1;
    localparam int IRQ_EXT = 2;

    localparam int ID_SW  = 3;
    localparam int ID_TMR = 7;
    localparam int ID_EXT = 11;

    localparam logic [ENG_W-1:0] ENG_EXECUTE = ENG_W'(2);
    localparam logic [ENG_W-1:0] ENG_TRAP    = ENG_W'(3);

    typedef enum logic {
        CTL_IDLE,
        CTL_WAIT
    } ctl_state_t;

    function automatic logic [XLEN-1:0] irq_cause(input int idx);
        logic [XLEN-1:0] c;
        c = '0;
        unique case (idx)
            IRQ_SW:  c[7:0] = 8'(ID_SW);
            IRQ_TMR: c[7:0] = 8'(ID_TMR);
            default: c[7:0] = 8'(ID_EXT);
        endcase
        c[XLEN-1] = 1'b1;
        return c;
    endfunction

    function automatic logic [XLEN-1:0] mip_map(input logic [NUM_IRQ-1:0] q);
        logic [XLEN-1:0] r;
        r         = '0;
        r[ID_SW]  = q[IRQ_SW];
        r[ID_TMR] = q[IRQ_TMR];
        r[ID_EXT] = q[IRQ_EXT];
        return r;
    endfunction

endpackage

// File: rtl/trap_sticky_buf.sv
module trap_sticky_buf #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] bit_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                bit_q[g] <= 1'b0;
            end else begin
                bit_q[g] <= (bit_q[g] | set_i[g]) & ~clr_i[g];
            end
        end

        // R8: a clear strobe removes its bit on the next edge, even against a set
        a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i[g] |=> !q_o[g]);
    end

    assign q_o = bit_q;

endmodule

// File: rtl/trap_prio.sv
module trap_prio
    import trap_ctrl_pkg::*;
(
    input  logic [NUM_EXC-1:0] exc_buf_i,
    input  logic [NUM_IRQ-1:0] irq_elig_i,
    output logic               hit_o,
    output logic [XLEN-1:0]    cause_o,
    output logic [NUM_IRQ-1:0] ack_mask_o
);

    always_comb begin
        hit_o      = 1'b0;
        cause_o    = '0;
        ack_mask_o = '0;
        if (|exc_buf_i) begin
            hit_o = 1'b1;
            for (int i = NUM_EXC - 1; i >= 0; i--) begin
                if (exc_buf_i[i]) begin
                    cause_o = XLEN'(i);
                end
            end
        end else if (irq_elig_i[IRQ_EXT]) begin
            hit_o               = 1'b1;
            cause_o             = irq_cause(IRQ_EXT);
            ack_mask_o[IRQ_EXT] = 1'b1;
        end else if (irq_elig_i[IRQ_SW]) begin
            hit_o              = 1'b1;
            cause_o            = irq_cause(IRQ_SW);
            ack_mask_o[IRQ_SW] = 1'b1;
        end else if (irq_elig_i[IRQ_TMR]) begin
            hit_o               = 1'b1;
            cause_o             = irq_cause(IRQ_TMR);
            ack_mask_o[IRQ_TMR] = 1'b1;
        end
    end

    // R5: an exception choice never acknowledges an interrupt
    always_comb begin
        if (|exc_buf_i) begin
            a_r5_exc_first: assert (ack_mask_o == '0);
        end
    end

endmodule

// File: rtl/trap_capture_ctrl.sv
module trap_capture_ctrl
    import trap_ctrl_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EXC-1:0] exc_strobe_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic               gie_i,
    input  logic [ENG_W-1:0]   eng_state_i,
    input  logic               start_ack_i,
    output logic [XLEN-1:0]    mcause_o,
    output logic [NUM_EXC-1:0] exc_src_o,
    output logic               exc_clr_o,
    output logic [NUM_IRQ-1:0] irq_ack_o,
    output logic               start_req_o,
    output logic [XLEN-1:0]    mip_o
);

    ctl_state_t         state_q, state_d;
    logic [NUM_EXC-1:0] exc_q;
    logic [NUM_IRQ-1:0] irq_q;
    logic [NUM_IRQ-1:0] irq_elig;
    logic               irq_window;
    logic               sel_hit;
    logic [XLEN-1:0]    sel_cause;
    logic [NUM_IRQ-1:0] sel_ack;
    logic               take;

    logic [XLEN-1:0]    mcause_q;
    logic [NUM_EXC-1:0] exc_src_q;
    logic               exc_clr_q;
    logic [NUM_IRQ-1:0] irq_ack_q;

    trap_sticky_buf #(.W(NUM_EXC)) u_exc_buf (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (exc_strobe_i),
        .clr_i  (exc_src_q & {NUM_EXC{exc_clr_q}}),
        .q_o    (exc_q)
    );

    trap_sticky_buf #(.W(NUM_IRQ)) u_irq_buf (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (irq_i),
        .clr_i  (irq_ack_q),
        .q_o    (irq_q)
    );

    assign irq_window = (eng_state_i == ENG_EXECUTE) || (eng_state_i == ENG_TRAP);
    assign irq_elig   = irq_q & irq_en_i & {NUM_IRQ{gie_i & irq_window}};

    trap_prio u_prio (
        .exc_buf_i  (exc_q),
        .irq_elig_i (irq_elig),
        .hit_o      (sel_hit),
        .cause_o    (sel_cause),
        .ack_mask_o (sel_ack)
    );

    assign take = (state_q == CTL_IDLE) && sel_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE: if (sel_hit)     state_d = CTL_WAIT;
            CTL_WAIT: if (start_ack_i) state_d = CTL_IDLE;
            default:                   state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mcause_q  <= '0;
            exc_src_q <= '0;
            exc_clr_q <= 1'b0;
            irq_ack_q <= '0;
        end else begin
            exc_clr_q <= 1'b0;
            irq_ack_q <= '0;
            if (take) begin
                mcause_q  <= sel_cause;
                exc_src_q <= exc_q;
                exc_clr_q <= 1'b1;
                irq_ack_q <= sel_ack;
            end
        end
    end

    assign mcause_o    = mcause_q;
    assign exc_src_o   = exc_src_q;
    assign exc_clr_o   = exc_clr_q;
    assign irq_ack_o   = irq_ack_q;
    assign start_req_o = (state_q == CTL_WAIT);
    assign mip_o       = mip_map(irq_q);

    a_r6_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_req_o && !start_ack_i) |=> start_req_o);

    a_r6_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_req_o && start_ack_i) |=> !start_req_o);

    a_r7_cause_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_req_o && !start_ack_i) |=> $stable(mcause_o));

    a_r8_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_clr_o |=> !exc_clr_o);

    a_r8_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_ack_o));

    a_r5_irq_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_ack_o != '0) |-> $past((eng_state_i == ENG_EXECUTE) || (eng_state_i == ENG_TRAP)));

    a_r3_irq_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_ack_o != '0) |-> mcause_o[XLEN-1]);

    a_r8_ack_with_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_clr_o |-> start_req_o);

endmodule

// File: tb/trap_capture_ctrl_bench.sv
`timescale 1ns/1ps
module trap_capture_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  exc_strobe = '0;
    logic [2:0]  irq = '0;
    logic [2:0]  irq_en = '0;
    logic        gie = 1'b0;
    logic [2:0]  eng_state = '0;
    logic        start_ack = 1'b0;
    logic [31:0] mcause;
    logic [2:0]  exc_src;
    logic        exc_clr;
    logic [2:0]  irq_ack;
    logic        start_req;
    logic [31:0] mip;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    trap_capture_ctrl u_trap_capture_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .exc_strobe_i(exc_strobe),
        .irq_i       (irq),
        .irq_en_i    (irq_en),
        .gie_i       (gie),
        .eng_state_i (eng_state),
        .start_ack_i (start_ack),
        .mcause_o    (mcause),
        .exc_src_o   (exc_src),
        .exc_clr_o   (exc_clr),
        .irq_ack_o   (irq_ack),
        .start_req_o (start_req),
        .mip_o       (mip)
    );

    typedef struct packed {
        logic [2:0]  exc;
        logic [2:0]  irq;
        logic [2:0]  en;
        logic        gie;
        logic [2:0]  st;
        logic        taken;
        logic [31:0] cause;
        logic [2:0]  ack;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{3'b001, 3'b000, 3'b111, 1'b1, 3'd0, 1'b1, 32'h0000_0000, 3'b000},
        '{3'b010, 3'b000, 3'b111, 1'b1, 3'd2, 1'b1, 32'h0000_0001, 3'b000},
        '{3'b100, 3'b000, 3'b000, 1'b0, 3'd5, 1'b1, 32'h0000_0002, 3'b000},
        '{3'b110, 3'b000, 3'b111, 1'b1, 3'd2, 1'b1, 32'h0000_0001, 3'b000},
        '{3'b000, 3'b001, 3'b111, 1'b1, 3'd2, 1'b1, 32'h8000_0003, 3'b001},
        '{3'b000, 3'b010, 3'b111, 1'b1, 3'd2, 1'b1, 32'h8000_0007, 3'b010},
        '{3'b000, 3'b100, 3'b111, 1'b1, 3'd3, 1'b1, 32'h8000_000B, 3'b100},
        '{3'b000, 3'b111, 3'b111, 1'b1, 3'd2, 1'b1, 32'h8000_000B, 3'b100},
        '{3'b000, 3'b011, 3'b111, 1'b1, 3'd3, 1'b1, 32'h8000_0003, 3'b001},
        '{3'b000, 3'b111, 3'b011, 1'b1, 3'd2, 1'b1, 32'h8000_0003, 3'b001},
        '{3'b000, 3'b111, 3'b111, 1'b0, 3'd2, 1'b0, 32'h0000_0000, 3'b000},
        '{3'b000, 3'b001, 3'b111, 1'b1, 3'd0, 1'b0, 32'h0000_0000, 3'b000},
        '{3'b100, 3'b111, 3'b111, 1'b1, 3'd0, 1'b1, 32'h0000_0002, 3'b000},
        '{3'b001, 3'b100, 3'b111, 1'b1, 3'd2, 1'b1, 32'h0000_0000, 3'b000}
    };

    function automatic logic [31:0] exp_mip(input logic [2:0] q);
        return {20'b0, q[2], 3'b0, q[1], 3'b0, q[0], 3'b0};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_idle_outputs(input string req);
        check(start_req == 1'b0, req, "start_req", 32'(start_req), 32'd0);
        check(mcause == 32'd0, req, "mcause", mcause, 32'd0);
        check(exc_src == 3'd0, req, "exc_src", 32'(exc_src), 32'd0);
        check(exc_clr == 1'b0, req, "exc_clr", 32'(exc_clr), 32'd0);
        check(irq_ack == 3'd0, req, "irq_ack", 32'(irq_ack), 32'd0);
        check(mip == 32'd0, req, "mip", mip, 32'd0);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset with requests present on the inputs
        exc_strobe = 3'b111;
        irq        = 3'b111;
        repeat (2) @(negedge clk);
        check_idle_outputs("R1");
        exc_strobe = '0;
        irq        = '0;
        rst_n      = 1'b1;
        @(negedge clk);
        check_idle_outputs("R1");

        // Table-driven patterns: R2 R3 R4 R5 R6 R8 R9
        for (int k = 0; k < NV; k++) begin
            vec_t  v;
            string tag;
            v = TBL[k];
            if (v.exc != 3'b000)                      tag = "R2";
            else if (!v.taken && v.st != 3'd2 && v.st != 3'd3) tag = "R5";
            else if (!v.taken)                        tag = "R4";
            else                                      tag = "R3";
            reset_dut();
            exc_strobe = v.exc;
            irq        = v.irq;
            irq_en     = v.en;
            gie        = v.gie;
            eng_state  = v.st;
            @(negedge clk);
            exc_strobe = '0;
            irq        = '0;
            @(negedge clk);
            check(start_req == v.taken, "R6", "start_req rise", 32'(start_req), 32'(v.taken));
            if (v.taken) begin
                check(mcause == v.cause, tag, "cause", mcause, v.cause);
                check(exc_src == v.exc, "R2", "exc_src", 32'(exc_src), 32'(v.exc));
                check(exc_clr == 1'b1, "R8", "exc_clr pulse", 32'(exc_clr), 32'd1);
                check(irq_ack == v.ack, "R8", "irq_ack mask", 32'(irq_ack), 32'(v.ack));
            end
            @(negedge clk);
            check(exc_clr == 1'b0, "R8", "exc_clr width", 32'(exc_clr), 32'd0);
            check(irq_ack == 3'd0, "R8", "irq_ack width", 32'(irq_ack), 32'd0);
            check(mip == exp_mip(v.irq & ~v.ack), "R9", "mip", mip, exp_mip(v.irq & ~v.ack));
            if (v.taken) begin
                repeat (3) @(negedge clk);
                check(start_req == 1'b1, "R6", "start_req hold", 32'(start_req), 32'd1);
                start_ack = 1'b1;
                @(negedge clk);
                start_ack = 1'b0;
                check(start_req == 1'b0, "R6", "start_req drop", 32'(start_req), 32'd0);
            end
        end

        // R7: single outstanding trap, later request buffered and taken after ack
        reset_dut();
        irq_en    = 3'b111;
        gie       = 1'b1;
        eng_state = 3'd2;
        exc_strobe = 3'b001;
        @(negedge clk);
        exc_strobe = '0;
        @(negedge clk);
        check(mcause == 32'd0, "R7", "first cause", mcause, 32'd0);
        @(negedge clk);
        exc_strobe = 3'b100;
        irq        = 3'b100;
        @(negedge clk);
        exc_strobe = '0;
        irq        = '0;
        repeat (2) @(negedge clk);
        check(start_req == 1'b1, "R7", "still pending", 32'(start_req), 32'd1);
        check(mcause == 32'd0, "R7", "cause held", mcause, 32'd0);
        check(exc_clr == 1'b0, "R7", "no second accept", 32'(exc_clr), 32'd0);
        check(mip == 32'h0000_0800, "R9", "mip while pending", mip, 32'h0000_0800);
        start_ack = 1'b1;
        @(negedge clk);
        start_ack = 1'b0;
        check(start_req == 1'b0, "R6", "drop before re-accept", 32'(start_req), 32'd0);
        @(negedge clk);
        check(start_req == 1'b1, "R7", "buffered taken", 32'(start_req), 32'd1);
        check(mcause == 32'd2, "R7", "buffered cause", mcause, 32'd2);
        check(exc_src == 3'b100, "R7", "buffered src", 32'(exc_src), 32'd4);
        check(irq_ack == 3'd0, "R5", "exception beats irq", 32'(irq_ack), 32'd0);
        start_ack = 1'b1;
        @(negedge clk);
        start_ack = 1'b0;
        @(negedge clk);
        check(mcause == 32'h8000_000B, "R7", "irq after exception", mcause, 32'h8000_000B);

        // R1: reset while a request is outstanding
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle_outputs("R1");
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule